// File: doc/BRIEF.md
# Parallel LCD Write Cycle Sequencer

This block drives write cycles to an external panel over an 8080-style parallel bus. A client hands over one word at a time through a valid/ready handshake, together with a flag that selects command or data. The block then drives the command/data select line and the data bus. It lowers the active-low chip select, pulses the active-low write strobe, and releases chip select again. Each phase lasts for its own programmed number of clock cycles.

Four 8-bit timing counts set the phases:

- address-to-select setup;
- select-to-strobe setup;
- strobe width;
- strobe-to-release hold.

All four are written together through a load strobe. The block copies them into its own storage when it accepts a request, so rewriting them during a cycle changes only later transfers. A busy flag covers the whole cycle. A one-cycle done pulse marks the release of chip select. The block accepts the next request in that same cycle, so transfers can run back to back with one cycle of chip select high between them.

Top module: `lcd_wr_seq`

## Requirements
- R1: Out of reset, lcd_cs_no and lcd_wr_no are 1, busy_o and done_o are 0 and req_ready_o is 1. The timing counts reset to 0 for address setup, 0 for strobe setup, 1 for strobe width and 0 for hold.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 1 only while busy_o is 0, and busy_o is 1 from the cycle after acceptance until chip select is released.
- R3: lcd_dc_o takes req_is_data_i (1 = data, 0 = command) and lcd_data_o takes req_data_i in the cycle after acceptance. Both hold constant for every busy cycle.
- R4: After acceptance, lcd_cs_no stays 1 for exactly cfg_cs_setup_i busy cycles before going low. A count of 0 drives it low in the first busy cycle.
- R5: After chip select goes low, lcd_wr_no stays 1 for exactly cfg_wr_setup_i cycles before going low. A count of 0 lowers both in the same cycle.
- R6: lcd_wr_no is low for exactly cfg_wr_active_i cycles in one contiguous pulse, and for one cycle when that count is 0.
- R7: After lcd_wr_no returns high, lcd_cs_no stays low for exactly cfg_wr_hold_i cycles. A count of 0 raises both in the same cycle.
- R8: done_o is 1 for exactly one cycle: the cycle in which lcd_cs_no returns to 1 and busy_o falls.
- R9: The counts in force are those loaded (cfg_we_i high at an edge) before the acceptance edge. A load during a transfer does not change that transfer and applies to the next one.
- R10: lcd_wr_no is never 0 while lcd_cs_no is 1, and the phase order within a transfer is always select setup, strobe low, strobe high, select release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the four timing counts |
| cfg_cs_setup_i | input | CNT_W | Cycles from select line valid to chip select low |
| cfg_wr_setup_i | input | CNT_W | Cycles from chip select low to strobe low |
| cfg_wr_active_i | input | CNT_W | Strobe low width (0 acts as 1) |
| cfg_wr_hold_i | input | CNT_W | Cycles from strobe high to chip select high |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_is_data_i | input | 1 | 1 = data word, 0 = command word |
| req_data_i | input | DATA_W | Word to write |
| lcd_dc_o | output | 1 | Command/data select to the panel |
| lcd_cs_no | output | 1 | Chip select, active low |
| lcd_wr_no | output | 1 | Write strobe, active low |
| lcd_data_o | output | DATA_W | Parallel data bus |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at chip select release |

## Verification
A corrupted phase register or phase counter shows first as a phase of the wrong length. Within one cycle of the error, a strobe edge or chip select edge moves earlier or later than its programmed count. A wrong phase transition can also put the strobe low outside the chip select window, which the port-level checks catch in the same cycle. A bad capture register or a wrongly timed acceptance shows on the data bus or select line during the busy window, at the first cycle after the transfer starts. The bench sweeps every combination of counts from 0 to 3 and adds one long setting. It counts each phase length cycle by cycle at the pins and compares it with the programmed value.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;
  localparam int NUM_PH  = 4;
  localparam int PH_IW   = 2;
  localparam int ACT_IDX = 2;

  // phase codes 0..3 index the count array; order is the cycle order
  typedef enum logic [2:0] {
    PH_ADDR = 3'd0,
    PH_CSW  = 3'd1,
    PH_ACT  = 3'd2,
    PH_HOLD = 3'd3,
    PH_IDLE = 3'd4
  } phase_e;
endpackage

// File: rtl/lcd_wr_cfg.sv
module lcd_wr_cfg
  import lcd_wr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0]   val_i,
  output logic [NUM_PH-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar g = 0; g < NUM_PH; g++) begin : g_cnt
    localparam logic [CNT_W-1:0] RST_VAL = (g == ACT_IDX) ? CNT_W'(1) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_o[g] <= RST_VAL;
      else if (we_i) cnt_o[g] <= val_i[g];
    end
  end
endmodule

// File: rtl/lcd_wr_fsm.sv
module lcd_wr_fsm
  import lcd_wr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         accept_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0] cfg_i,
  output phase_e                       st_q_o,
  output phase_e                       st_d_o
);
  phase_e                       st_q, st_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic [NUM_PH-1:0][CNT_W-1:0] lat_q, lat_d, eff;

  // lowest phase at or after start with a nonzero count
  function automatic phase_e first_live(input int start,
                                        input logic [NUM_PH-1:0][CNT_W-1:0] c);
    phase_e r;
    r = PH_IDLE;
    for (int i = NUM_PH - 1; i >= 0; i--)
      if (i >= start && c[i] != '0) r = phase_e'(3'(i));
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input phase_e p,
                                              input logic [NUM_PH-1:0][CNT_W-1:0] c);
    logic [2:0] pv;
    pv = p;
    return c[pv[PH_IW-1:0]];
  endfunction

  // strobe width of zero is promoted to one
  always_comb begin
    for (int i = 0; i < NUM_PH; i++) begin
      eff[i] = cfg_i[i];
      if (i == ACT_IDX && cfg_i[i] == '0) eff[i] = CNT_W'(1);
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (st_q == PH_IDLE) begin
      if (accept_i) begin
        lat_d = eff;
        st_d  = first_live(0, eff);
        cnt_d = len_of(st_d, eff) - 1'b1;
      end
    end else if (cnt_q == '0) begin
      st_d = first_live(int'(st_q) + 1, lat_q);
      if (st_d != PH_IDLE) cnt_d = len_of(st_d, lat_q) - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;
endmodule

// File: rtl/lcd_wr_out.sv
module lcd_wr_out
  import lcd_wr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              is_data_i,
  input  logic [DATA_W-1:0] data_i,
  input  phase_e            st_q_i,
  input  phase_e            st_d_i,
  output logic              dc_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic              done_o
);
  // pins decoded from next phase and registered: no decode glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_o   <= 1'b0;
      data_o <= '0;
      cs_no  <= 1'b1;
      wr_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      if (accept_i) begin
        dc_o   <= is_data_i;
        data_o <= data_i;
      end
      cs_no  <= (st_d_i == PH_IDLE) || (st_d_i == PH_ADDR);
      wr_no  <= (st_d_i != PH_ACT);
      done_o <= (st_d_i == PH_IDLE) && (st_q_i != PH_IDLE);
    end
  end
endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_cs_setup_i,
  input  logic [CNT_W-1:0]  cfg_wr_setup_i,
  input  logic [CNT_W-1:0]  cfg_wr_active_i,
  input  logic [CNT_W-1:0]  cfg_wr_hold_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_data_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              lcd_dc_o,
  output logic              lcd_cs_no,
  output logic              lcd_wr_no,
  output logic [DATA_W-1:0] lcd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [NUM_PH-1:0][CNT_W-1:0] cfg_val, cfg_cnt;
  phase_e                       st_q, st_d;
  logic                         accept;

  assign cfg_val = {cfg_wr_hold_i, cfg_wr_active_i, cfg_wr_setup_i, cfg_cs_setup_i};

  assign busy_o      = (st_q != PH_IDLE);
  assign req_ready_o = ~busy_o;
  assign accept      = req_valid_i & req_ready_o;

  lcd_wr_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .val_i  (cfg_val),
    .cnt_o  (cfg_cnt)
  );

  lcd_wr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .cfg_i    (cfg_cnt),
    .st_q_o   (st_q),
    .st_d_o   (st_d)
  );

  lcd_wr_out #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .is_data_i (req_is_data_i),
    .data_i    (req_data_i),
    .st_q_i    (st_q),
    .st_d_i    (st_d),
    .dc_o      (lcd_dc_o),
    .data_o    (lcd_data_o),
    .cs_no     (lcd_cs_no),
    .wr_no     (lcd_wr_no),
    .done_o    (done_o)
  );
endmodule

// File: rtl/lcd_wr_seq_chk.sv
module lcd_wr_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              lcd_dc_o,
  input logic              lcd_cs_no,
  input logic              lcd_wr_no,
  input logic [DATA_W-1:0] lcd_data_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r10_wr_within_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_wr_no |-> !lcd_cs_no);

  a_r3_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(lcd_data_o) && $stable(lcd_dc_o)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_cs_no) |-> (done_o && !busy_o));

  a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> busy_o);
endmodule

bind lcd_wr_seq lcd_wr_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .lcd_dc_o    (lcd_dc_o),
  .lcd_cs_no   (lcd_cs_no),
  .lcd_wr_no   (lcd_wr_no),
  .lcd_data_o  (lcd_data_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/lcd_wr_seq_bench.sv
module lcd_wr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_cs = '0, cfg_ws = '0, cfg_wa = '0, cfg_wh = '0;
  logic          valid = 1'b0, is_data = 1'b0;
  logic [DW-1:0] din = '0;
  logic          ready, dc, cs_n, wr_n, busy, done;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  int mid_a, mid_s, mid_w, mid_h;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_wr_seq #(.CNT_W(CW), .DATA_W(DW)) u_lcd_wr_seq (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .cfg_we_i        (cfg_we),
    .cfg_cs_setup_i  (cfg_cs),
    .cfg_wr_setup_i  (cfg_ws),
    .cfg_wr_active_i (cfg_wa),
    .cfg_wr_hold_i   (cfg_wh),
    .req_valid_i     (valid),
    .req_ready_o     (ready),
    .req_is_data_i   (is_data),
    .req_data_i      (din),
    .lcd_dc_o        (dc),
    .lcd_cs_no       (cs_n),
    .lcd_wr_no       (wr_n),
    .lcd_data_o      (dout),
    .busy_o          (busy),
    .done_o          (done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prog(input int a, input int s, input int w, input int h);
    @(negedge clk);
    cfg_cs = CW'(a); cfg_ws = CW'(s); cfg_wa = CW'(w); cfg_wh = CW'(h);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // caller has set valid/is_data/din at a negedge; returns at the done cycle
  task automatic xfer(input int ea, input int es, input int ew, input int eh,
                      input logic edc, input logic [DW-1:0] ed,
                      input bit hold, input bit mid);
    int na = 0, ns = 0, nw = 0, nh = 0, n = 0;
    int ewe;
    bit saw_cs = 0, saw_wr = 0, bad_ord = 0, bad_bus = 0, bad_rdy = 0, bad_wr = 0;
    ewe = (ew == 0) ? 1 : ew;
    chk("R2", "ready while idle", int'(ready), 1);
    @(negedge clk);
    if (!hold) valid = 1'b0;
    else din = ~ed;
    while (busy && n < 5000) begin
      n++;
      if (cs_n && wr_n) begin
        if (saw_cs) bad_ord = 1;
        na++;
      end else if (!cs_n && wr_n) begin
        saw_cs = 1;
        if (saw_wr) nh++;
        else ns++;
      end else if (!cs_n && !wr_n) begin
        saw_cs = 1;
        if (nh != 0) bad_ord = 1;
        saw_wr = 1;
        nw++;
      end else bad_wr = 1;
      if (dc !== edc || dout !== ed) bad_bus = 1;
      if (ready !== 1'b0 || done !== 1'b0) bad_rdy = 1;
      if (mid && n == 2) begin
        cfg_cs = CW'(mid_a); cfg_ws = CW'(mid_s); cfg_wa = CW'(mid_w); cfg_wh = CW'(mid_h);
        cfg_we = 1'b1;
      end else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    chk("R4", "addr setup cycles", na, ea);
    chk("R5", "strobe setup cycles", ns, es);
    chk("R6", "strobe low cycles", nw, ewe);
    chk("R7", "hold cycles", nh, eh);
    chk("R3", "bus held during busy", int'(bad_bus), 0);
    chk("R2", "ready low and no done while busy", int'(bad_rdy), 0);
    chk("R10", "strobe outside select", int'(bad_wr), 0);
    chk("R10", "phase order", int'(bad_ord), 0);
    chk("R8", "done at release", int'({done, cs_n, wr_n, busy}), 4'b1110);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", int'(cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cs_n after reset", int'(cs_n), 1);
    chk("R1", "wr_n after reset", int'(wr_n), 1);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "ready after reset", int'(ready), 1);

    // R1: default counts 0/0/1/0
    valid = 1'b1; is_data = 1'b0; din = 16'h00a5;
    xfer(0, 0, 1, 0, 1'b0, 16'h00a5, 1'b0, 1'b0);

    // R4 R5 R6 R7: full sweep of 0..3 on every count
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 4; h++) begin
            logic [DW-1:0] d;
            d = DW'((a * 64 + s * 16 + w * 4 + h) * 40503 + 7);
            prog(a, s, w, h);
            valid = 1'b1; is_data = d[0]; din = d;
            xfer(a, s, w, h, d[0], d, 1'b0, 1'b0);
          end

    // long setting
    prog(255, 17, 200, 255);
    valid = 1'b1; is_data = 1'b1; din = 16'hbeef;
    xfer(255, 17, 200, 255, 1'b1, 16'hbeef, 1'b0, 1'b0);

    // R9: load during a transfer applies only to the next one
    prog(2, 2, 2, 2);
    mid_a = 5; mid_s = 0; mid_w = 3; mid_h = 1;
    valid = 1'b1; is_data = 1'b0; din = 16'h1234;
    xfer(2, 2, 2, 2, 1'b0, 16'h1234, 1'b0, 1'b1);
    @(negedge clk);
    valid = 1'b1; is_data = 1'b1; din = 16'h4321;
    xfer(5, 0, 3, 1, 1'b1, 16'h4321, 1'b0, 1'b0);

    // R2: request held high during busy, back-to-back acceptance
    prog(1, 1, 1, 1);
    valid = 1'b1; is_data = 1'b1; din = 16'hc0de;
    xfer(1, 1, 1, 1, 1'b1, 16'hc0de, 1'b1, 1'b0);
    is_data = 1'b0; din = 16'h5a5a;
    xfer(1, 1, 1, 1, 1'b0, 16'h5a5a, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8", "done lasts one cycle", int'(done), 0);
    chk("R2", "idle after last transfer", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule